// File: doc/BRIEF.md
# Radix-2 In-Place FFT Engine

This block computes a complex discrete Fourier transform of power-of-two length N = 2^LOG2N. It uses the decimation-in-time form of the radix-2 algorithm. A host writes the time-domain samples through a load port, using their natural time index. The engine files each sample at the bit-reversed slot itself, so the host never has to permute the data.

A start pulse launches LOG2N passes of butterflies over the same storage. Each pass halves every result. At the end the busy flag falls, the done flag rises, and the spectrum can be read in natural frequency order through a combinational read port.

Each butterfly forms the product t = W·b with one complex multiplier, where W = cos − j·sin is the twiddle factor. It then writes back (a + t)/2 and (a − t)/2. The twiddle values are computed during elaboration as signed fixed-point numbers with TW−1 fraction bits. The output is therefore the transform divided by N.

Top module: `fft_r2_engine`

## Requirements
- R1: While reset is held and on the first edge after it, busy and done are both low.
- R2: A load with loadValid high while busy is low stores the sample for natural time index loadIndex. After a run, bin k is read at readIndex = k, and readRe/readIm follow readIndex in the same cycle.
- R3: Bin k equals (1/N)·Σn x[n]·e^(−j2πnk/N), rounded, within ±3 LSB on each of the real and imaginary parts. This holds for complex inputs of up to 12-bit signed magnitude.
- R4: A start pulse sampled while busy is low makes busy high from the next edge. Busy stays high for exactly LOG2N·N/2 clock cycles, one butterfly per cycle. On the edge where busy falls, done rises.
- R5: Done stays high until the next accepted start, and it is cleared on the edge where busy rises. Busy and done are never high together.
- R6: Loads presented while busy is high change neither the stored data nor the result.
- R7: A start pulse while busy is high is ignored, and the run keeps its length.
- R8: The halving in every pass keeps 12-bit full-scale input from wrapping. An input of +2047 and −2047 on alternating samples gives bin N/2 within ±3 LSB of 2047, and the other bins within ±3 LSB of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadValid | input | 1 | Write one sample this cycle |
| loadIndex | input | LOG2N | Natural time index of the sample |
| loadRe | input | DW | Real part, signed |
| loadIm | input | DW | Imaginary part, signed |
| start | input | 1 | Launch a transform (one-cycle pulse) |
| busy | output | 1 | Butterfly passes in progress |
| done | output | 1 | Result ready, held until next start |
| readIndex | input | LOG2N | Frequency bin to read |
| readRe | output | DW | Real part of the selected bin |
| readIm | output | DW | Imaginary part of the selected bin |

## Verification
The bench builds the engine with LOG2N = 4, DW = 16 and TW = 16. This is a 16-point transform whose 12-bit inputs have four bits of headroom, which is the configuration the requirements target. At this size a single run lasts only 32 butterfly cycles, so the exact done timing can be counted, and a run can be disturbed with loads and a stray start in mid-flight. Impulses at non-zero offsets, a pure tone, DC, complex pseudo-random data and alternating full-scale samples each drive a different set of twiddle indices and address pairings. All of them are compared bin by bin against a floating-point transform computed in the bench.

// File: rtl/r2fft_pkg.sv
`timescale 1ns/1ps
package r2fft_pkg;

  // Widest address the command struct can carry; LOG2N must stay below it.
  localparam int ADDR_MAX = 12;

  typedef enum logic [0:0] {CtlIdle = 1'b0, CtlRun = 1'b1} ctlState_e;

  // Strobes and addresses handed from the sequencer to the datapath.
  typedef struct packed {
    logic                bflyEn;
    logic [ADDR_MAX-1:0] topAddr;
    logic [ADDR_MAX-1:0] botAddr;
    logic [ADDR_MAX-1:0] twIdx;
  } bflyCmd_t;

  // pi scaled by 2^28
  localparam longint PI_Q28 = 64'sd843314857;

  function automatic longint angleQ28(int k, int n);
    return (PI_Q28 * 2 * longint'(k)) / longint'(n);
  endfunction

  function automatic longint cosQ28(longint th);
    longint th2, term, acc;
    th2  = (th * th) >>> 28;
    term = longint'(1) <<< 28;
    acc  = term;
    for (int i = 1; i <= 14; i++) begin
      term = -((term * th2) >>> 28) / longint'((2 * i - 1) * (2 * i));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic longint sinQ28(longint th);
    longint th2, term, acc;
    th2  = (th * th) >>> 28;
    term = th;
    acc  = term;
    for (int i = 1; i <= 14; i++) begin
      term = -((term * th2) >>> 28) / longint'((2 * i) * (2 * i + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Round a Q28 value to fracBits fraction bits, saturating symmetrically.
  function automatic int toFrac(longint vQ28, int fracBits);
    longint shifted, lim;
    shifted = (vQ28 + (longint'(1) <<< (27 - fracBits))) >>> (28 - fracBits);
    lim     = (longint'(1) <<< fracBits) - 1;
    if (shifted > lim)  shifted = lim;
    if (shifted < -lim) shifted = -lim;
    return int'(shifted);
  endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
`timescale 1ns/1ps
module fft_twiddle_rom #(
  parameter int LOG2N = 4,
  parameter int TW    = 16
) (
  input  logic [LOG2N-2:0]       twIdx,
  output logic signed [TW-1:0]   wCos,
  output logic signed [TW-1:0]   wSin
);
  localparam int NPTS = 1 << LOG2N;
  localparam int HALF = NPTS / 2;

  logic signed [TW-1:0] cosTab [HALF];
  logic signed [TW-1:0] sinTab [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_tw
    localparam longint TH = r2fft_pkg::angleQ28(k, NPTS);
    localparam logic signed [TW-1:0] CV =
      TW'(r2fft_pkg::toFrac(r2fft_pkg::cosQ28(TH), TW - 1));
    localparam logic signed [TW-1:0] SV =
      TW'(r2fft_pkg::toFrac(r2fft_pkg::sinQ28(TH), TW - 1));
    assign cosTab[k] = CV;
    assign sinTab[k] = SV;
  end

  assign wCos = cosTab[twIdx];
  assign wSin = sinTab[twIdx];
endmodule

// File: rtl/fft_butterfly.sv
`timescale 1ns/1ps
module fft_butterfly #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic signed [DW-1:0] aRe,
  input  logic signed [DW-1:0] aIm,
  input  logic signed [DW-1:0] bRe,
  input  logic signed [DW-1:0] bIm,
  input  logic signed [TW-1:0] wCos,
  input  logic signed [TW-1:0] wSin,
  output logic signed [DW-1:0] sumRe,
  output logic signed [DW-1:0] sumIm,
  output logic signed [DW-1:0] difRe,
  output logic signed [DW-1:0] difIm
);
  localparam int FB = TW - 1;
  localparam int PW = DW + TW + 2;

  logic signed [PW-1:0] prodRe, prodIm;
  logic signed [PW-1:0] aReS, aImS, rndBit;
  logic signed [PW-1:0] sumReF, sumImF, difReF, difImF;

  always_comb begin
    // t = b * (cos - j sin), kept at full precision
    prodRe = PW'(bRe) * PW'(wCos) + PW'(bIm) * PW'(wSin);
    prodIm = PW'(bIm) * PW'(wCos) - PW'(bRe) * PW'(wSin);
    aReS   = PW'(aRe) <<< FB;
    aImS   = PW'(aIm) <<< FB;
    rndBit = PW'(1) <<< FB;
    // one rounding covers both the fraction drop and the halving
    sumReF = aReS + prodRe + rndBit;
    sumImF = aImS + prodIm + rndBit;
    difReF = aReS - prodRe + rndBit;
    difImF = aImS - prodIm + rndBit;
  end

  assign sumRe = DW'(sumReF >>> (FB + 1));
  assign sumIm = DW'(sumImF >>> (FB + 1));
  assign difRe = DW'(difReF >>> (FB + 1));
  assign difIm = DW'(difImF >>> (FB + 1));
endmodule

// File: rtl/fft_datapath.sv
`timescale 1ns/1ps
module fft_datapath #(
  parameter int LOG2N = 4,
  parameter int DW    = 16,
  parameter int TW    = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  r2fft_pkg::bflyCmd_t     cmd,
  input  logic                    wrLoad,
  input  logic [LOG2N-1:0]        loadIndex,
  input  logic signed [DW-1:0]    loadRe,
  input  logic signed [DW-1:0]    loadIm,
  input  logic [LOG2N-1:0]        readIndex,
  output logic signed [DW-1:0]    readRe,
  output logic signed [DW-1:0]    readIm
);
  localparam int NPTS = 1 << LOG2N;
  localparam int AM   = r2fft_pkg::ADDR_MAX;

  logic signed [DW-1:0] memRe [NPTS];
  logic signed [DW-1:0] memIm [NPTS];

  logic [LOG2N-1:0] loadSlot;
  logic [LOG2N-1:0] topA, botA;
  logic [LOG2N-2:0] twA;
  logic             unusedCmdBits;

  // bit-reversed placement of incoming samples
  for (genvar b = 0; b < LOG2N; b++) begin : g_rev
    assign loadSlot[b] = loadIndex[LOG2N-1-b];
  end

  assign topA = cmd.topAddr[LOG2N-1:0];
  assign botA = cmd.botAddr[LOG2N-1:0];
  assign twA  = cmd.twIdx[LOG2N-2:0];
  assign unusedCmdBits = ^{cmd.topAddr[AM-1:LOG2N], cmd.botAddr[AM-1:LOG2N],
                           cmd.twIdx[AM-1:LOG2N-1]};

  logic signed [TW-1:0] wCos, wSin;
  logic signed [DW-1:0] sumRe, sumIm, difRe, difIm;

  fft_twiddle_rom #(.LOG2N(LOG2N), .TW(TW)) u_rom (
    .twIdx (twA),
    .wCos  (wCos),
    .wSin  (wSin)
  );

  fft_butterfly #(.DW(DW), .TW(TW)) u_bfly (
    .aRe   (memRe[topA]),
    .aIm   (memIm[topA]),
    .bRe   (memRe[botA]),
    .bIm   (memIm[botA]),
    .wCos  (wCos),
    .wSin  (wSin),
    .sumRe (sumRe),
    .sumIm (sumIm),
    .difRe (difRe),
    .difIm (difIm)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPTS; i++) begin
        memRe[i] <= '0;
        memIm[i] <= '0;
      end
    end else if (cmd.bflyEn) begin
      memRe[topA] <= sumRe;
      memIm[topA] <= sumIm;
      memRe[botA] <= difRe;
      memIm[botA] <= difIm;
    end else if (wrLoad) begin
      memRe[loadSlot] <= loadRe;
      memIm[loadSlot] <= loadIm;
    end
  end

  assign readRe = memRe[readIndex];
  assign readIm = memIm[readIndex];
endmodule

// File: rtl/fft_control.sv
`timescale 1ns/1ps
module fft_control #(
  parameter int LOG2N = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output r2fft_pkg::bflyCmd_t  cmd
);
  import r2fft_pkg::*;

  localparam int SW = (LOG2N > 2) ? $clog2(LOG2N) : 1;
  localparam int BW = LOG2N - 1;
  localparam logic [SW-1:0] LAST_STAGE = SW'(LOG2N - 1);
  localparam logic [BW-1:0] LAST_BFLY  = '1;

  ctlState_e      state;
  logic [SW-1:0]  stage;
  logic [BW-1:0]  bfly;

  logic [LOG2N-1:0] bflyExt, halfBit, halfMask, posIn, grpBase, topAddr, botAddr, twFull;
  logic [SW-1:0]    twShift;

  // address pairing and twiddle step for the current stage
  always_comb begin
    bflyExt  = {1'b0, bfly};
    halfBit  = LOG2N'(1) << stage;
    halfMask = halfBit - LOG2N'(1);
    posIn    = bflyExt & halfMask;
    grpBase  = ((bflyExt >> stage) << stage) << 1;
    topAddr  = grpBase | posIn;
    botAddr  = topAddr | halfBit;
    twShift  = LAST_STAGE - stage;
    twFull   = posIn << twShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CtlIdle;
      stage <= '0;
      bfly  <= '0;
      done  <= 1'b0;
    end else begin
      unique case (state)
        CtlIdle: begin
          if (start) begin
            state <= CtlRun;
            stage <= '0;
            bfly  <= '0;
            done  <= 1'b0;
          end
        end
        CtlRun: begin
          if (bfly == LAST_BFLY) begin
            bfly <= '0;
            if (stage == LAST_STAGE) begin
              state <= CtlIdle;
              done  <= 1'b1;
            end else begin
              stage <= stage + SW'(1);
            end
          end else begin
            bfly <= bfly + BW'(1);
          end
        end
        default: state <= CtlIdle;
      endcase
    end
  end

  assign busy        = (state == CtlRun);
  assign cmd.bflyEn  = busy;
  assign cmd.topAddr = ADDR_MAX'(topAddr);
  assign cmd.botAddr = ADDR_MAX'(botAddr);
  assign cmd.twIdx   = ADDR_MAX'(twFull);
endmodule

// File: rtl/fft_r2_engine.sv
`timescale 1ns/1ps
module fft_r2_engine #(
  parameter int LOG2N = 4,
  parameter int DW    = 16,
  parameter int TW    = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadValid,
  input  logic [LOG2N-1:0]      loadIndex,
  input  logic signed [DW-1:0]  loadRe,
  input  logic signed [DW-1:0]  loadIm,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  input  logic [LOG2N-1:0]      readIndex,
  output logic signed [DW-1:0]  readRe,
  output logic signed [DW-1:0]  readIm
);
  r2fft_pkg::bflyCmd_t cmd;
  logic wrLoad;

  assign wrLoad = loadValid && !busy;

  fft_control #(.LOG2N(LOG2N)) u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .cmd   (cmd)
  );

  fft_datapath #(.LOG2N(LOG2N), .DW(DW), .TW(TW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wrLoad    (wrLoad),
    .loadIndex (loadIndex),
    .loadRe    (loadRe),
    .loadIm    (loadIm),
    .readIndex (readIndex),
    .readRe    (readRe),
    .readIm    (readIm)
  );
endmodule

// File: rtl/fft_r2_checker.sv
`timescale 1ns/1ps
module fft_r2_checker #(
  parameter int LOG2N = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done
);
  localparam int RUNLEN = LOG2N * (1 << LOG2N) / 2;

  logic [31:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runCnt <= '0;
    else if (busy) runCnt <= runCnt + 32'd1;
    else           runCnt <= '0;
  end

  // R1: outputs idle right after a reset edge
  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> (!busy && !done));

  // R4: an accepted start raises busy on the next edge
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R4, R7: every run lasts exactly RUNLEN cycles, stray starts or not
  p_run_length_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runCnt == RUNLEN));

  // R4: done rises together with the end of busy
  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R5: busy and done exclusive
  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R5: done held until a new start
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
endmodule

bind fft_r2_engine fft_r2_checker #(.LOG2N(LOG2N)) u_fft_r2_checker (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done)
);

// File: tb/test_fft_r2_engine.sv
`timescale 1ns/1ps
module test_fft_r2_engine;
  localparam int LOG2N  = 4;
  localparam int DW     = 16;
  localparam int TW     = 16;
  localparam int NPTS   = 1 << LOG2N;
  localparam int RUNLEN = LOG2N * NPTS / 2;
  localparam int TOL    = 3;
  localparam real PI    = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0;
  logic [LOG2N-1:0] loadIndex = '0;
  logic signed [DW-1:0] loadRe = '0, loadIm = '0;
  logic start = 1'b0;
  logic busy, done;
  logic [LOG2N-1:0] readIndex = '0;
  logic signed [DW-1:0] readRe, readIm;

  int checkCount = 0;
  int failCount  = 0;

  typedef struct {
    int    idx;
    int    expRe;
    int    expIm;
    string req;
  } sbItem_t;

  sbItem_t sbQ[$];
  int xr[NPTS];
  int xi[NPTS];
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  fft_r2_engine #(.LOG2N(LOG2N), .DW(DW), .TW(TW)) i_fft_r2_engine (
    .clk       (clk),
    .rstN      (rstN),
    .loadValid (loadValid),
    .loadIndex (loadIndex),
    .loadRe    (loadRe),
    .loadIm    (loadIm),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .readIndex (readIndex),
    .readRe    (readRe),
    .readIm    (readIm)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int roundReal(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int absInt(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int nextRand12();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 4096) - 2048;
  endfunction

  // driver: load samples in natural order
  task automatic loadAll();
    for (int i = 0; i < NPTS; i++) begin
      @(negedge clk);
      loadValid = 1'b1;
      loadIndex = LOG2N'(i);
      loadRe    = DW'(xr[i]);
      loadIm    = DW'(xi[i]);
    end
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  // driver: reference transform pushed to the scoreboard
  task automatic pushExpected(input string req);
    for (int k = 0; k < NPTS; k++) begin
      real sr, si, ang;
      sbItem_t it;
      sr = 0.0;
      si = 0.0;
      for (int n = 0; n < NPTS; n++) begin
        ang = 2.0 * PI * real'(n * k) / real'(NPTS);
        sr  = sr + real'(xr[n]) * $cos(ang) + real'(xi[n]) * $sin(ang);
        si  = si + real'(xi[n]) * $cos(ang) - real'(xr[n]) * $sin(ang);
      end
      it.idx   = k;
      it.expRe = roundReal(sr / real'(NPTS));
      it.expIm = roundReal(si / real'(NPTS));
      it.req   = req;
      sbQ.push_back(it);
    end
    wait (sbQ.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  // driver: launch and time a run; optionally disturb it with loads and a start
  task automatic runFft(input string req, input bit disturb);
    int cycles;
    @(negedge clk);
    start  = 1'b1;
    cycles = 0;
    while (cycles < 200) begin
      @(negedge clk);
      cycles++;
      start     = 1'b0;
      loadValid = 1'b0;
      if (cycles == 1) begin
        check(busy == 1'b1, "R4", "busy after start", int'(busy), 1);
        check(done == 1'b0, "R5", "done cleared at start", int'(done), 0);
      end
      if (done) break;
      if (disturb && cycles >= 2 && cycles <= 20) begin
        loadValid = 1'b1;
        loadIndex = LOG2N'(cycles);
        loadRe    = DW'(999);
        loadIm    = -DW'(999);
        if (cycles == 5) start = 1'b1;  // R7: stray start while busy
      end
    end
    loadValid = 1'b0;
    check(cycles == RUNLEN + 1, disturb ? "R7" : "R4", "cycles start to done",
          cycles, RUNLEN + 1);
    check(busy == 1'b0, "R4", "busy low at done", int'(busy), 0);
  endtask

  // monitor: pop expected bins and compare against the read port
  initial begin
    forever begin
      sbItem_t it;
      wait (sbQ.size() != 0);
      it = sbQ.pop_front();
      @(negedge clk);
      readIndex = LOG2N'(it.idx);
      @(negedge clk);
      checkCount++;
      if (absInt(int'(readRe) - it.expRe) > TOL || absInt(int'(readIm) - it.expIm) > TOL) begin
        failCount++;
        $display("FAIL %s bin %0d: actual (%0d,%0d) expected (%0d,%0d)", it.req, it.idx,
                 int'(readRe), int'(readIm), it.expRe, it.expIm);
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 150000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);

    // R2: impulse at a non-zero offset exposes index mapping
    for (int i = 0; i < NPTS; i++) begin xr[i] = 0; xi[i] = 0; end
    xr[3] = 1600;
    loadAll();
    runFft("R4", 1'b0);
    pushExpected("R2");

    // R3: impulse at zero, imaginary only
    for (int i = 0; i < NPTS; i++) begin xr[i] = 0; xi[i] = 0; end
    xi[0] = -1200;
    loadAll();
    runFft("R4", 1'b0);
    pushExpected("R3");

    // R3: DC level
    for (int i = 0; i < NPTS; i++) begin xr[i] = 800; xi[i] = 0; end
    loadAll();
    runFft("R4", 1'b0);
    pushExpected("R3");

    // R3: tone at bin 2
    for (int i = 0; i < NPTS; i++) begin
      xr[i] = roundReal(2000.0 * $cos(2.0 * PI * 2.0 * real'(i) / real'(NPTS)));
      xi[i] = 0;
    end
    loadAll();
    runFft("R4", 1'b0);
    pushExpected("R3");

    // R3: complex pseudo-random 12-bit data
    for (int i = 0; i < NPTS; i++) begin xr[i] = nextRand12(); xi[i] = nextRand12(); end
    loadAll();
    runFft("R4", 1'b0);
    pushExpected("R3");

    // R8: alternating full scale
    for (int i = 0; i < NPTS; i++) begin xr[i] = (i % 2 == 0) ? 2047 : -2047; xi[i] = 0; end
    loadAll();
    runFft("R4", 1'b0);
    pushExpected("R8");

    // R6, R7: loads and a start during the run must not disturb it
    for (int i = 0; i < NPTS; i++) begin xr[i] = nextRand12(); xi[i] = nextRand12(); end
    loadAll();
    runFft("R7", 1'b1);
    pushExpected("R6");

    // R5: done holds while no start arrives
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R5", "done held", int'(done), 1);
    check(busy == 1'b0, "R5", "busy low while done", int'(busy), 0);

    finishRun();
  end
endmodule